// File: doc/BRIEF.md
# Synchronizer Test Sequencer

This block drives a self-checking test of a clock-domain-crossing circuit. When a run is launched, it fills an on-chip source buffer with a pseudo-random word stream from a programmable seed. It then plays that stream out, one word per cycle, toward the synchronizer under test. The words that come back from the synchronizer are stored in one of several destination buffers, in the order they arrive. A comparison pass then walks a chosen destination buffer against the source buffer. For every address it logs a record in a result buffer and adds to a running error total.

A host programs the seed, the run length, the two buffer selections and two opaque settings words. The settings words pick the synchronizer variant and set the clock and delay setup; the block only holds them and presents them on output pins. After `busy` drops, the host reads the error total through the same register port and fetches the per-address records through a separate read port. Four independent control pieces cooperate: configuration, the fill/stream sequencer, the capture writer and the checker.

Top module: `sync_test_sequencer`

## Requirements
- R1: After reset, `busy` and `dut_valid` are 0. The registers read seed 0xACE1, length 0, destination select 0, both settings words 0 and error total 0.
- R2: `cfg_rdata` shows the register chosen by `cfg_addr` in the same cycle. The addresses are: 0 seed; 1 length; 2 buffer select, with the write destination in bits [1:0] and the compare destination in bits [5:4]; 3 variant-select word, driven on `sel_cfg`; 4 clock/delay word, driven on `dly_cfg`; 5 error total, read-only. Every other address reads 0.
- R3: A register write issued while `busy` is high has no effect.
- R4: A `start` pulse while idle makes `busy` read 1 from the next cycle on. A `start` pulse while busy is ignored and does not disturb the run.
- R5: Source word 0 is the seed; a zero seed is replaced by 1. Each following word is the previous word shifted right by one, then XORed with 0xB400 when the previous word's bit 0 was 1.
- R6: The run length L is the length register, except that a value of 0 or a value above DEPTH (32) means DEPTH.
- R7: Exactly L words are presented with `dut_valid` high, in source address order, in consecutive cycles.
- R8: Only cycles with `rx_valid` high are captured. The captured words go into the write-destination buffer at addresses 0, 1, 2, ... in arrival order, and capture stops after L words.
- R9: For every address a < L, the result record at `res_raddr` = a holds a in bits [21:17], a mismatch flag in bit 16 (received word differs from source word a), and the received word in bits [15:0].
- R10: The error total is cleared by a launch and, after the run, equals the number of records with the mismatch flag set.
- R11: The comparison uses the compare-destination buffer, which may differ from the write destination. `busy` drops in the cycle after the last record is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse |
| busy | output | 1 | High from launch until the comparison completes |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register address, used for both write and read |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data |
| sel_cfg | output | 16 | Held variant-select word |
| dly_cfg | output | 16 | Held clock/delay word |
| dut_data | output | 16 | Word sent to the synchronizer |
| dut_valid | output | 1 | `dut_data` carries a word |
| rx_valid | input | 1 | Returned word is valid |
| rx_data | input | 16 | Word returned by the synchronizer |
| res_raddr | input | 5 | Result record read address |
| res_rdata | output | 22 | Result record at `res_raddr` |

## Verification
A wrong fill-register state or a wrong fill step shows on `dut_data` at the first bad word of the stream, which is L+1 cycles or more after launch. A lost or duplicated capture pointer increment shows up two ways: the records show shifted or repeated received words, or `busy` never drops because the capture count never reaches L. A stuck comparison address or a bad error accumulator shows in the records and the error total once `busy` falls. A wrong buffer selection only shows when the compare destination differs from the write destination, so that case is driven on purpose.

// File: rtl/sts_pkg.sv
package sts_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_STREAM, ST_DONE} seq_state_e;

   localparam logic [2:0] A_SEED = 3'd0;
   localparam logic [2:0] A_LEN  = 3'd1;
   localparam logic [2:0] A_DEST = 3'd2;
   localparam logic [2:0] A_SEL  = 3'd3;
   localparam logic [2:0] A_DLY  = 3'd4;
   localparam logic [2:0] A_ERR  = 3'd5;
endpackage

// File: rtl/sts_lfsr.sv
module sts_lfsr #(
   parameter int unsigned DW = 16
) (
   input  logic [DW-1:0] cur,
   output logic [DW-1:0] nxt
);
   logic [DW-1:0] mask;

   generate
      if (DW == 8) begin : g_w8
         assign mask = DW'(8'hB8);
      end else if (DW == 16) begin : g_w16
         assign mask = DW'(16'hB400);
      end else if (DW == 32) begin : g_w32
         assign mask = DW'(32'h8020_0003);
      end else begin : g_bad
         $error("sts_lfsr: DW must be 8, 16 or 32");
         assign mask = '0;
      end
   endgenerate

   assign nxt = (cur >> 1) ^ (cur[0] ? mask : '0);
endmodule

// File: rtl/sts_regs.sv
module sts_regs
   import sts_pkg::*;
#(
   parameter int unsigned DW  = 16,
   parameter int unsigned LW  = 6,
   parameter int unsigned DSW = 2,
   parameter int unsigned DEPTH = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           busy,
   input  logic           cfg_we,
   input  logic [2:0]     cfg_addr,
   input  logic [DW-1:0]  cfg_wdata,
   input  logic [LW-1:0]  err_cnt,
   output logic [DW-1:0]  cfg_rdata,
   output logic [DW-1:0]  seed,
   output logic [LW-1:0]  len_eff,
   output logic [DSW-1:0] wr_dest,
   output logic [DSW-1:0] cmp_dest,
   output logic [DW-1:0]  sel_cfg,
   output logic [DW-1:0]  dly_cfg
);
   localparam logic [LW-1:0] FULL_LEN = LW'(DEPTH);
   logic [LW-1:0] len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seed     <= DW'(16'hACE1);
         len_q    <= '0;
         wr_dest  <= '0;
         cmp_dest <= '0;
         sel_cfg  <= '0;
         dly_cfg  <= '0;
      end else if (cfg_we && !busy) begin
         case (cfg_addr)
            A_SEED: seed    <= cfg_wdata;
            A_LEN:  len_q   <= cfg_wdata[LW-1:0];
            A_DEST: begin
               wr_dest  <= cfg_wdata[DSW-1:0];
               cmp_dest <= cfg_wdata[4 +: DSW];
            end
            A_SEL:  sel_cfg <= cfg_wdata;
            A_DLY:  dly_cfg <= cfg_wdata;
            default: ;
         endcase
      end
   end

   assign len_eff = (len_q == '0 || len_q > FULL_LEN) ? FULL_LEN : len_q;

   always_comb begin
      cfg_rdata = '0;
      case (cfg_addr)
         A_SEED: cfg_rdata = seed;
         A_LEN:  cfg_rdata = DW'(len_q);
         A_DEST: begin
            cfg_rdata[DSW-1:0]  = wr_dest;
            cfg_rdata[4 +: DSW] = cmp_dest;
         end
         A_SEL:  cfg_rdata = sel_cfg;
         A_DLY:  cfg_rdata = dly_cfg;
         A_ERR:  cfg_rdata = DW'(err_cnt);
         default: cfg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/sts_stream.sv
module sts_stream
   import sts_pkg::*;
#(
   parameter int unsigned DW    = 16,
   parameter int unsigned DEPTH = 32,
   parameter int unsigned AW    = 5,
   parameter int unsigned LW    = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] seed,
   input  logic [LW-1:0] len_eff,
   input  logic          cmp_done,
   input  logic [AW-1:0] src_raddr,
   output logic [DW-1:0] src_rdata,
   output logic [DW-1:0] dut_data,
   output logic          dut_valid,
   output logic          busy,
   output logic          arm
);
   seq_state_e    st;
   logic [AW-1:0] idx;
   logic [DW-1:0] lfsr_q;
   logic [DW-1:0] lfsr_nxt;
   logic          at_last;
   logic [DW-1:0] src_mem [DEPTH];

   sts_lfsr #(.DW(DW)) u_lfsr (.cur(lfsr_q), .nxt(lfsr_nxt));

   assign at_last   = ({1'b0, idx} == LW'(len_eff - LW'(1)));
   assign arm       = (st == ST_IDLE) && start;
   assign busy      = (st != ST_IDLE);
   assign src_rdata = src_mem[src_raddr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         idx       <= '0;
         lfsr_q    <= '0;
         dut_valid <= 1'b0;
         dut_data  <= '0;
      end else begin
         dut_valid <= 1'b0;
         case (st)
            ST_IDLE: if (start) begin
               st     <= ST_FILL;
               idx    <= '0;
               lfsr_q <= (seed == '0) ? DW'(1) : seed;
            end
            ST_FILL: begin
               lfsr_q <= lfsr_nxt;
               if (at_last) begin
                  st  <= ST_STREAM;
                  idx <= '0;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            ST_STREAM: begin
               dut_valid <= 1'b1;
               dut_data  <= src_mem[idx];
               if (at_last) st <= ST_DONE;
               else idx <= idx + 1'b1;
            end
            ST_DONE: if (cmp_done) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (st == ST_FILL) src_mem[idx] <= lfsr_q;
   end
endmodule

// File: rtl/sts_capture.sv
module sts_capture #(
   parameter int unsigned DW    = 16,
   parameter int unsigned DEPTH = 32,
   parameter int unsigned NDST  = 4,
   parameter int unsigned AW    = 5,
   parameter int unsigned LW    = 6,
   parameter int unsigned DSW   = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           arm,
   input  logic [LW-1:0]  len_eff,
   input  logic [DSW-1:0] wr_dest,
   input  logic           rx_valid,
   input  logic [DW-1:0]  rx_data,
   input  logic [DSW-1:0] rd_sel,
   input  logic [AW-1:0]  rd_addr,
   output logic [DW-1:0]  rd_data,
   output logic           done
);
   logic          active;
   logic [AW-1:0] cnt;
   logic          take;
   logic          last;
   logic [DW-1:0] bank_rd [NDST];

   assign take = active && rx_valid;
   assign last = ({1'b0, cnt} == LW'(len_eff - LW'(1)));
   assign done = take && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (arm) begin
         active <= 1'b1;
         cnt    <= '0;
      end else if (take) begin
         if (last) active <= 1'b0;
         else cnt <= cnt + 1'b1;
      end
   end

   for (genvar g = 0; g < NDST; g++) begin : g_bank
      logic [DW-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (take && wr_dest == DSW'(g)) mem[cnt] <= rx_data;
      end
      assign bank_rd[g] = mem[rd_addr];
   end

   assign rd_data = (32'(rd_sel) < NDST) ? bank_rd[rd_sel] : '0;
endmodule

// File: rtl/sts_compare.sv
module sts_compare #(
   parameter int unsigned DW    = 16,
   parameter int unsigned DEPTH = 32,
   parameter int unsigned AW    = 5,
   parameter int unsigned LW    = 6,
   parameter int unsigned RW    = 22
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm,
   input  logic          go,
   input  logic [LW-1:0] len_eff,
   input  logic [DW-1:0] src_rdata,
   input  logic [DW-1:0] dst_rdata,
   output logic [AW-1:0] rd_addr,
   input  logic [AW-1:0] res_raddr,
   output logic [RW-1:0] res_rdata,
   output logic [LW-1:0] err_cnt,
   output logic          done
);
   logic          active;
   logic          mm;
   logic          last;
   logic [RW-1:0] res_mem [DEPTH];

   assign mm        = (src_rdata != dst_rdata);
   assign last      = ({1'b0, rd_addr} == LW'(len_eff - LW'(1)));
   assign done      = active && last;
   assign res_rdata = res_mem[res_raddr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         rd_addr <= '0;
         err_cnt <= '0;
      end else if (arm) begin
         active  <= 1'b0;
         err_cnt <= '0;
      end else if (go) begin
         active  <= 1'b1;
         rd_addr <= '0;
      end else if (active) begin
         err_cnt <= err_cnt + LW'(mm);
         if (last) active <= 1'b0;
         else rd_addr <= rd_addr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (active) res_mem[rd_addr] <= {rd_addr, mm, dst_rdata};
   end
endmodule

// File: rtl/sync_test_sequencer.sv
module sync_test_sequencer #(
   parameter int unsigned DW    = 16,
   parameter int unsigned DEPTH = 32,
   parameter int unsigned NDST  = 4,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned LW   = AW + 1,
   localparam int unsigned DSW  = $clog2(NDST),
   localparam int unsigned RW   = AW + 1 + DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   input  logic          cfg_we,
   input  logic [2:0]    cfg_addr,
   input  logic [DW-1:0] cfg_wdata,
   output logic [DW-1:0] cfg_rdata,
   output logic [DW-1:0] sel_cfg,
   output logic [DW-1:0] dly_cfg,
   output logic [DW-1:0] dut_data,
   output logic          dut_valid,
   input  logic          rx_valid,
   input  logic [DW-1:0] rx_data,
   input  logic [AW-1:0] res_raddr,
   output logic [RW-1:0] res_rdata
);
   if (DEPTH < 2) begin : g_chk_depth
      $error("sync_test_sequencer: DEPTH must be at least 2");
   end
   if (NDST < 2 || NDST > 16) begin : g_chk_ndst
      $error("sync_test_sequencer: NDST must be 2..16");
   end

   logic [DW-1:0]  seed_w;
   logic [LW-1:0]  len_w;
   logic [DSW-1:0] wrd_w;
   logic [DSW-1:0] cmpd_w;
   logic [LW-1:0]  err_w;
   logic           arm_w;
   logic           capd_w;
   logic           cmpdone_w;
   logic [AW-1:0]  caddr_w;
   logic [DW-1:0]  srcrd_w;
   logic [DW-1:0]  dstrd_w;

   sts_regs #(.DW(DW), .LW(LW), .DSW(DSW), .DEPTH(DEPTH)) u_regs (
      .clk(clk), .rst_n(rst_n), .busy(busy),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .err_cnt(err_w), .cfg_rdata(cfg_rdata),
      .seed(seed_w), .len_eff(len_w), .wr_dest(wrd_w), .cmp_dest(cmpd_w),
      .sel_cfg(sel_cfg), .dly_cfg(dly_cfg)
   );

   sts_stream #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .LW(LW)) u_stream (
      .clk(clk), .rst_n(rst_n), .start(start), .seed(seed_w), .len_eff(len_w),
      .cmp_done(cmpdone_w), .src_raddr(caddr_w), .src_rdata(srcrd_w),
      .dut_data(dut_data), .dut_valid(dut_valid), .busy(busy), .arm(arm_w)
   );

   sts_capture #(.DW(DW), .DEPTH(DEPTH), .NDST(NDST), .AW(AW), .LW(LW), .DSW(DSW)) u_cap (
      .clk(clk), .rst_n(rst_n), .arm(arm_w), .len_eff(len_w), .wr_dest(wrd_w),
      .rx_valid(rx_valid), .rx_data(rx_data), .rd_sel(cmpd_w), .rd_addr(caddr_w),
      .rd_data(dstrd_w), .done(capd_w)
   );

   sts_compare #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .LW(LW), .RW(RW)) u_cmp (
      .clk(clk), .rst_n(rst_n), .arm(arm_w), .go(capd_w), .len_eff(len_w),
      .src_rdata(srcrd_w), .dst_rdata(dstrd_w), .rd_addr(caddr_w),
      .res_raddr(res_raddr), .res_rdata(res_rdata), .err_cnt(err_w), .done(cmpdone_w)
   );
endmodule

// File: rtl/sts_checker.sv
module sts_checker #(
   parameter int unsigned DW  = 16,
   parameter int unsigned LW  = 6,
   parameter int unsigned DSW = 2
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic           busy,
   input logic           dut_valid,
   input logic           cmp_done,
   input logic [LW-1:0]  err_cnt,
   input logic [LW-1:0]  len_eff,
   input logic [DW-1:0]  seed,
   input logic [DSW-1:0] wr_dest
);
   p_busy_needs_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   p_valid_inside_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dut_valid |-> busy);

   p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(seed) && $stable(len_eff) && $stable(wr_dest)));

   p_err_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (err_cnt <= len_eff));

   p_busy_ends_on_compare_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(cmp_done));
endmodule

bind sync_test_sequencer sts_checker #(.DW(DW), .LW(LW), .DSW(DSW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .dut_valid(dut_valid),
   .cmp_done(cmpdone_w), .err_cnt(err_w), .len_eff(len_w), .seed(seed_w),
   .wr_dest(wrd_w)
);

// File: tb/sim_sync_test_sequencer.sv
module sim_sync_test_sequencer;
   localparam int DEPTH = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        busy;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic [15:0] sel_cfg;
   logic [15:0] dly_cfg;
   logic [15:0] dut_data;
   logic        dut_valid;
   logic        rx_valid = 1'b0;
   logic [15:0] rx_data = '0;
   logic [4:0]  res_raddr = '0;
   logic [21:0] res_rdata;

   int n_checks = 0;
   int n_fails  = 0;
   logic [15:0] src_m [64];
   logic [15:0] dst_m [4][64];

   always #4 clk = ~clk;

   sync_test_sequencer u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .sel_cfg(sel_cfg), .dly_cfg(dly_cfg),
      .dut_data(dut_data), .dut_valid(dut_valid),
      .rx_valid(rx_valid), .rx_data(rx_data),
      .res_raddr(res_raddr), .res_rdata(res_rdata)
   );

   function automatic logic [15:0] lfsr_next(input logic [15:0] s);
      return (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0000);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_read(input logic [2:0] a, output logic [15:0] v);
      @(negedge clk);
      cfg_addr = a;
      #1 v = cfg_rdata;
   endtask

   task automatic run(input logic [15:0] sd, input int lcfg, input int wr,
                      input int cm, input int ncor, input bit poke);
      int L; int sent; int fr; int fw; int cyc; int exp_err;
      bit gap; bit started;
      logic [15:0] s; logic [15:0] v; logic [15:0] mask;
      logic [15:0] fifo [64];
      bit corr [64];
      string rq;
      L = (lcfg == 0 || lcfg > DEPTH) ? DEPTH : lcfg;
      cfg_write(3'd0, sd);
      cfg_write(3'd1, 16'(lcfg));
      cfg_write(3'd2, 16'((cm << 4) | wr));
      s = (sd == 16'h0) ? 16'h1 : sd;
      for (int i = 0; i < L; i++) begin src_m[i] = s; s = lfsr_next(s); end
      for (int i = 0; i < 64; i++) corr[i] = 1'b0;
      for (int c = 0; c < ncor; c++) corr[$urandom % L] = 1'b1;
      sent = 0; fr = 0; fw = 0; cyc = 0; gap = 0; started = 0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(busy == 1'b1, "R4", "busy after launch", 32'(busy), 1);
      while (cyc < 3000) begin
         @(negedge clk);
         cyc++;
         if (!busy) break;
         if (dut_valid) begin
            if (sent < L) chk(dut_data == src_m[sent], sent == 0 ? "R5" : "R7",
                              "stream word", 32'(dut_data), 32'(src_m[sent]));
            else chk(1'b0, "R7", "extra stream word", 32'(sent), 32'(L));
            if (gap) chk(1'b0, "R7", "stream gap", 32'(sent), 32'(L));
            fifo[fw % 64] = dut_data; fw++; sent++; started = 1;
         end else if (started) gap = 1;
         if (fr < fw && ($urandom % 4) != 0) begin
            mask = corr[fr] ? (16'h1 << (fr % 16)) : 16'h0;
            rx_valid = 1'b1;
            rx_data  = fifo[fr % 64] ^ mask;
            if (fr < L) dst_m[wr][fr] = rx_data;
            fr++;
         end else begin
            rx_valid = 1'b0;
         end
         if (poke) begin
            if (cyc == 5) start = 1'b1;
            if (cyc == 6) start = 1'b0;
            if (cyc == 7) begin cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = ~sd; end
            if (cyc == 8) cfg_we = 1'b0;
         end
      end
      rx_valid = 1'b0;
      if (cyc >= 3000) chk(1'b0, "R11", "run timeout", 32'(cyc), 3000);
      chk(sent == L, "R7", "words streamed", 32'(sent), 32'(L));
      exp_err = 0;
      rq = (cm != wr) ? "R11" : "R8";
      for (int a = 0; a < L; a++) begin
         bit em;
         em = (dst_m[cm][a] != src_m[a]);
         if (em) exp_err++;
         @(negedge clk);
         res_raddr = 5'(a);
         #1;
         chk(res_rdata[15:0] == dst_m[cm][a], rq, "record word",
             32'(res_rdata[15:0]), 32'(dst_m[cm][a]));
         chk(res_rdata[16] == em, "R9", "record mismatch flag", 32'(res_rdata[16]), 32'(em));
         chk(res_rdata[21:17] == 5'(a), "R9", "record address", 32'(res_rdata[21:17]), 32'(a));
      end
      cfg_read(3'd5, v);
      chk(v == 16'(exp_err), "R10", "error total", 32'(v), 32'(exp_err));
      if (poke) begin
         cfg_read(3'd0, v);
         chk(v == sd, "R3", "seed write while busy", 32'(v), 32'(sd));
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      logic [15:0] v;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R1", "busy reset", 32'(busy), 0);
      chk(dut_valid == 1'b0, "R1", "dut_valid reset", 32'(dut_valid), 0);
      cfg_read(3'd0, v); chk(v == 16'hACE1, "R1", "seed reset", 32'(v), 32'hACE1);
      cfg_read(3'd1, v); chk(v == 16'h0, "R1", "length reset", 32'(v), 0);
      cfg_read(3'd2, v); chk(v == 16'h0, "R1", "select reset", 32'(v), 0);
      cfg_read(3'd5, v); chk(v == 16'h0, "R1", "error total reset", 32'(v), 0);
      cfg_write(3'd3, 16'h5A3C);
      cfg_write(3'd4, 16'h0F71);
      cfg_write(3'd2, 16'h0031);
      cfg_write(3'd5, 16'h0007);
      cfg_read(3'd3, v); chk(v == 16'h5A3C && sel_cfg == 16'h5A3C, "R2", "select word", 32'(v), 32'h5A3C);
      cfg_read(3'd4, v); chk(v == 16'h0F71 && dly_cfg == 16'h0F71, "R2", "delay word", 32'(v), 32'h0F71);
      cfg_read(3'd2, v); chk(v == 16'h0031, "R2", "buffer select", 32'(v), 32'h31);
      cfg_read(3'd5, v); chk(v == 16'h0, "R2", "error total read-only", 32'(v), 0);
      cfg_read(3'd7, v); chk(v == 16'h0, "R2", "unmapped address", 32'(v), 0);
      cfg_write(3'd1, 16'd27);
      cfg_read(3'd1, v); chk(v == 16'd27, "R2", "length readback", 32'(v), 27);

      run(16'h1D2B, 20, 1, 1, 0, 1'b1);
      run(16'h0000, 0, 2, 2, 3, 1'b0);   // R5 zero seed, R6 length 0
      run(16'h7E11, 12, 3, 1, 0, 1'b0);  // R11 compare buffer differs
      run(16'hBEEF, 40, 0, 0, 2, 1'b0);  // R6 length above DEPTH
      run(16'h8001, 1, 0, 0, 1, 1'b0);   // single word
      for (int k = 0; k < 4; k++) begin
         int d;
         d = $urandom % 4;
         run(16'($urandom), 1 + ($urandom % 32), d, d, $urandom % 4, 1'b0);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end
endmodule